// File: doc/BRIEF.md
# Memory Background Pattern Tester

This block is a self-test sequencer for a single-port memory with 32-bit words and a synchronous read. Once started, it drives the memory's chip-select, write-enable, address and write data on its own. It sweeps five data backgrounds through the whole array. For each background it writes the pattern to every address, then reads every address back and compares the read word with the value that address should hold. A stuck-at-1 cell shows up under the all-zeros background. A stuck-at-0 cell shows up under the all-ones background. The two checkerboard words, used both uniformly and alternating by address, make every bit position hold both values with its neighbours at the opposite value.

The sequence stops at the first mismatch. At that point the block records three things: the address, the background index, and the bit-wise difference between the expected and read words. It then raises `done` together with `fail`. If all five backgrounds compare clean, it raises `done` together with `pass`. A `start` pulse given while the block is idle or finished clears the previous result and begins again at the first background and address 0.

Top module: `memtest_seq`

## Requirements
- R1: After reset, `mem_cs`, `done`, `pass` and `fail` are all low, and the block stays idle until `start` is seen.
- R2: Backgrounds with index 0, 1, 2 and 3 write and expect 0xFFFFFFFF, 0x00000000, 0xAAAAAAAA and 0x55555555 respectively, at every address.
- R3: Background index 4 writes and expects 0xAAAAAAAA at even addresses and 0x55555555 at odd addresses.
- R4: Each background takes 2*DEPTH+1 cycles. The first DEPTH cycles are writes (`mem_cs`=1, `mem_we`=1) to addresses 0 to DEPTH-1 in ascending order. The next DEPTH cycles are reads (`mem_cs`=1, `mem_we`=0) over the same ascending addresses. The last cycle has `mem_cs`=0. The first write of background 0 appears in the cycle after `start` is sampled.
- R5: Read data is taken one cycle after its read address is presented. This includes the read of address DEPTH-1, which is compared in the cycle with `mem_cs`=0 that ends the background.
- R6: If a read issued in cycle t mismatches, then from cycle t+2 onward `done`=1, `fail`=1 and `mem_cs`=0. At the same point `fail_addr` holds the address, `fail_bg` holds the background index (0 to 4), and `fail_xor` holds expected XOR read. These values hold until the next accepted `start`. `done` stays low up to and including cycle t+1.
- R7: With no mismatch, `done`=1 and `pass`=1 appear 5*(2*DEPTH+1) cycles after the first write cycle and hold until the next accepted `start`. `pass` and `fail` are never high together.
- R8: A `start` while `done` is high restarts the sequence at background 0, address 0, and clears `done`, `pass` and `fail`.
- R9: A `start` while a test is running has no effect on the memory access sequence or on the result.
- R10: `mem_we` is high only when `mem_cs` is high, and `mem_cs` is low while idle or finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) the test sequence |
| mem_cs | output | 1 | Memory chip-select |
| mem_we | output | 1 | Memory write-enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |
| done | output | 1 | Sequence finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Finished on a mismatch |
| fail_addr | output | AW | Address of the first mismatch |
| fail_bg | output | 3 | Background index of the first mismatch |
| fail_xor | output | 32 | Expected XOR read for the first mismatch |

## Verification
A wrong address counter or background index appears at the memory pins within one cycle: a skipped address, the wrong pattern, or a misplaced idle cycle. Comparing every pin on every cycle therefore catches it at once. A fault in the compare pipeline shows up differently. It moves the cycle in which `done` rises or corrupts `fail_addr` and `fail_xor`. Checking those against a predicted stop cycle pins the error to a single cycle. Faults on the last address and on single bits at either end of the word cover the corner where a read is compared during the closing idle cycle.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    localparam int WORD_W = 32;
    localparam int NUM_BG = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [2:0]        bg_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WR    = 3'd1,
        ST_RD    = 3'd2,
        ST_DRAIN = 3'd3,
        ST_FIN   = 3'd4
    } state_e;

    localparam word_t CHECK_A = 32'hAAAA_AAAA;
    localparam word_t CHECK_B = 32'h5555_5555;

    // Data background for a given index and address parity.
    function automatic word_t bg_word(input bg_t bg, input logic odd);
        case (bg)
            3'd0:    bg_word = '1;
            3'd1:    bg_word = '0;
            3'd2:    bg_word = CHECK_A;
            3'd3:    bg_word = CHECK_B;
            default: bg_word = odd ? CHECK_B : CHECK_A;
        endcase
    endfunction

endpackage

// File: rtl/memtest_pattern.sv
module memtest_pattern
    import memtest_pkg::*;
(
    input  bg_t   bg,
    input  logic  addr_odd,
    output word_t word
);
    always_comb word = bg_word(bg, addr_odd);
endmodule

// File: rtl/memtest_ctrl.sv
module memtest_ctrl
    import memtest_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mismatch,
    output logic          accept,
    output logic          mem_cs,
    output logic          mem_we,
    output logic          rd_issue,
    output logic [AW-1:0] addr,
    output bg_t           bg,
    output logic          done
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam bg_t           LAST_BG   = bg_t'(NUM_BG - 1);

    state_e        state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;
    bg_t           bg_q, bg_d;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_FIN);

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        bg_d    = bg_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (accept) begin
                    state_d = ST_WR;
                    addr_d  = '0;
                    bg_d    = '0;
                end
            end
            ST_WR: begin
                if (addr_q == LAST_ADDR) begin
                    state_d = ST_RD;
                    addr_d  = '0;
                end else begin
                    addr_d = addr_q + AW'(1);
                end
            end
            ST_RD: begin
                if (mismatch) begin
                    state_d = ST_FIN;
                end else if (addr_q == LAST_ADDR) begin
                    state_d = ST_DRAIN;
                end else begin
                    addr_d = addr_q + AW'(1);
                end
            end
            ST_DRAIN: begin
                if (mismatch || bg_q == LAST_BG) begin
                    state_d = ST_FIN;
                end else begin
                    state_d = ST_WR;
                    addr_d  = '0;
                    bg_d    = bg_q + bg_t'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            bg_q    <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            bg_q    <= bg_d;
        end
    end

    assign mem_cs   = (state_q == ST_WR) || (state_q == ST_RD);
    assign mem_we   = (state_q == ST_WR);
    assign rd_issue = (state_q == ST_RD);
    assign addr     = addr_q;
    assign bg       = bg_q;
    assign done     = (state_q == ST_FIN);

    // R4: write sweep advances one address per cycle
    p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR && $past(state_q) == ST_WR) |-> addr_q == $past(addr_q) + AW'(1));

    // R4: read sweep advances one address per cycle
    p_rd_step_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD && $past(state_q) == ST_RD) |-> addr_q == $past(addr_q) + AW'(1));

    // R10: memory is quiet once finished
    p_fin_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_cs);

    // R6/R7: the result holds until a new start
    p_done_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9: a start while running leaves the background index unchanged
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (start && (state_q == ST_WR || state_q == ST_RD)) |=> $stable(bg_q));

endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp
    import memtest_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          rd_issue,
    input  logic [AW-1:0] rd_addr,
    input  bg_t           rd_bg,
    input  word_t         rd_exp,
    input  word_t         mem_rdata,
    output logic          mismatch,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output bg_t           fail_bg,
    output word_t         fail_xor
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        bg_t           bg;
        word_t         exp;
    } pend_t;

    typedef struct packed {
        logic          hit;
        logic [AW-1:0] addr;
        bg_t           bg;
        word_t         diff;
    } result_t;

    pend_t   pend_q;
    result_t res_q;
    word_t   diff;

    assign diff     = mem_rdata ^ pend_q.exp;
    assign mismatch = pend_q.valid && !res_q.hit && (diff != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pend_q <= '0;
            res_q  <= '0;
        end else begin
            pend_q.valid <= rd_issue;
            pend_q.addr  <= rd_addr;
            pend_q.bg    <= rd_bg;
            pend_q.exp   <= rd_exp;
            if (mismatch) begin
                res_q.hit  <= 1'b1;
                res_q.addr <= pend_q.addr;
                res_q.bg   <= pend_q.bg;
                res_q.diff <= diff;
            end
        end
    end

    assign fail      = res_q.hit;
    assign fail_addr = res_q.addr;
    assign fail_bg   = res_q.bg;
    assign fail_xor  = res_q.diff;

    // R5: a compare only happens the cycle after a read was issued
    p_cmp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> $past(rd_issue));

    // R6: the first failure record is frozen until cleared
    p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> (fail && $stable(fail_addr) && $stable(fail_xor)));

    // R6: a recorded difference is never zero
    p_diff_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        fail |-> fail_xor != '0);

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
    import memtest_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          mem_cs,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [2:0]    fail_bg,
    output logic [31:0]   fail_xor
);
    logic  accept, mismatch, rd_issue;
    bg_t   bg;
    word_t pattern;

    memtest_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mismatch (mismatch),
        .accept   (accept),
        .mem_cs   (mem_cs),
        .mem_we   (mem_we),
        .rd_issue (rd_issue),
        .addr     (mem_addr),
        .bg       (bg),
        .done     (done)
    );

    memtest_pattern u_pat (
        .bg       (bg),
        .addr_odd (mem_addr[0]),
        .word     (pattern)
    );

    memtest_cmp #(.AW(AW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .rd_issue  (rd_issue),
        .rd_addr   (mem_addr),
        .rd_bg     (bg),
        .rd_exp    (pattern),
        .mem_rdata (mem_rdata),
        .mismatch  (mismatch),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_bg   (fail_bg),
        .fail_xor  (fail_xor)
    );

    assign mem_wdata = pattern;
    assign pass      = done && !fail;

    // R10: write strobe only inside a selected cycle
    p_we_in_cs_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_cs);

    // R6: a finish with a recorded failure never reports pass
    p_fail_done_r6: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> !pass);

endmodule

// File: tb/memtest_seq_tb.sv
`timescale 1ns/1ps
module memtest_seq_tb;
    localparam int D   = 16;
    localparam int AW  = 4;
    localparam int PER = 2 * D + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mem_cs, mem_we, done, pass, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [31:0]   mem_wdata, mem_rdata, fail_xor;
    logic [2:0]    fail_bg;

    int checks = 0;
    int failures = 0;

    int          f_addr = -1;
    logic [31:0] f_sa0 = '0;
    logic [31:0] f_sa1 = '0;
    logic [31:0] mem [D];

    always #2.5 clk = ~clk;

    memtest_seq #(.DEPTH(D), .AW(AW)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .mem_cs(mem_cs), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .fail_bg(fail_bg), .fail_xor(fail_xor)
    );

    // Memory with one optionally faulty word.
    always @(posedge clk) begin
        if (mem_cs && mem_we) begin
            if (int'(mem_addr) == f_addr) mem[mem_addr] <= (mem_wdata & ~f_sa0) | f_sa1;
            else                          mem[mem_addr] <= mem_wdata;
        end
        if (mem_cs && !mem_we) mem_rdata <= mem[mem_addr];
    end

    function automatic logic [31:0] pat(input int b, input int a);
        if (b == 0)      return 32'hFFFF_FFFF;
        else if (b == 1) return 32'h0000_0000;
        else if (b == 2) return 32'hAAAA_AAAA;
        else if (b == 3) return 32'h5555_5555;
        else             return (a % 2 == 0) ? 32'hAAAA_AAAA : 32'h5555_5555;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_case(input int fa, input logic [31:0] sa0, input logic [31:0] sa1,
                            input int ign_t, input string tag);
        int tfail = -1;
        int ebg = 0, eaddr = 0;
        logic [31:0] exor = '0;
        int end_t;
        f_addr = fa; f_sa0 = sa0; f_sa1 = sa1;
        for (int t = 0; t < 5 * PER; t++) begin
            int b = t / PER;
            int r = t % PER;
            if (r >= D && r < 2 * D && tfail < 0) begin
                int a = r - D;
                logic [31:0] w = pat(b, a);
                logic [31:0] got = (a == fa) ? ((w & ~sa0) | sa1) : w;
                if (got != w) begin
                    tfail = t; ebg = b; eaddr = a; exor = got ^ w;
                end
            end
        end
        end_t = (tfail >= 0) ? tfail + 2 : 5 * PER;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k <= end_t + 2; k++) begin
            start = (k == ign_t);
            if (k < end_t) begin
                int b = k / PER;
                int r = k % PER;
                string stag = (ign_t >= 0) ? "R9" : "R4";
                chk((k == 0) ? "R8" : "R6", {tag, " done low while running"}, done, 0);
                chk("R7", {tag, " pass low while running"}, pass, 0);
                chk("R6", {tag, " fail low while running"}, fail, 0);
                if (r < D) begin
                    chk(stag, {tag, " write cs"}, mem_cs, 1);
                    chk(stag, {tag, " write we"}, mem_we, 1);
                    chk(stag, {tag, " write addr"}, 32'(mem_addr), r);
                    chk((b == 4) ? "R3" : "R2", {tag, " write data"}, mem_wdata, pat(b, r));
                end else if (r < 2 * D) begin
                    chk(stag, {tag, " read cs"}, mem_cs, 1);
                    chk(stag, {tag, " read we"}, mem_we, 0);
                    chk(stag, {tag, " read addr"}, 32'(mem_addr), r - D);
                end else begin
                    chk("R10", {tag, " idle cs"}, mem_cs, 0);
                    chk("R10", {tag, " idle we"}, mem_we, 0);
                end
            end else begin
                chk("R10", {tag, " finished cs"}, mem_cs, 0);
                chk("R10", {tag, " finished we"}, mem_we, 0);
                chk((tfail >= 0) ? "R6" : "R7", {tag, " done"}, done, 1);
                chk("R7", {tag, " pass"}, pass, (tfail < 0));
                chk("R6", {tag, " fail"}, fail, (tfail >= 0));
                if (tfail >= 0) begin
                    chk((eaddr == D - 1) ? "R5" : "R6", {tag, " fail_addr"}, 32'(fail_addr), eaddr);
                    chk("R6", {tag, " fail_bg"}, 32'(fail_bg), ebg);
                    chk("R6", {tag, " fail_xor"}, fail_xor, exor);
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state and idle without start
        chk("R1", "cs after reset", mem_cs, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "pass after reset", pass, 0);
        chk("R1", "fail after reset", fail, 0);
        // R2 R3 R4 R7: clean memory passes all backgrounds
        run_case(-1, '0, '0, -1, "clean");
        // R6 R8: stuck-at-1 on bit 0 caught by all-zeros background
        run_case(5, '0, 32'h0000_0001, -1, "sa1_b0");
        // R6 R8: stuck-at-0 on bit 31 caught by all-ones background
        run_case(3, 32'h8000_0000, '0, -1, "sa0_b31");
        // R5: fault on the last address, compared during the closing cycle
        run_case(D - 1, '0, 32'h0000_0100, -1, "sa1_last");
        // R9: start during a clean run is ignored
        run_case(-1, '0, '0, 40, "ign_start");
        // R9: start during a failing run is ignored
        run_case(0, 32'h0000_0002, '0, 7, "ign_fail");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule